// File: doc/BRIEF.md
# Shared Synchronisation Flag Hub

This block keeps a small bank of shared single-bit flags that a group of sequencer engines and a host bus use to coordinate with one another. Any engine can raise or drop any flag by naming its index. Any engine can also ask whether a chosen flag currently sits at a chosen level, which lets it stall until a partner engine or the host has acted. Because this answer comes from the registered flag value, engines stay in lockstep to the exact cycle.

The host can set flags by writing ones to a mask and can clear them by writing ones to another mask. The host acknowledges an engine-raised event by clearing it this way. The low flags can also drive two system interrupt lines. Each line has its own enable mask, and each line output is registered. When requests collide on a flag in the same cycle, a fixed priority settles them: a set wins over a clear, and engine requests win over host writes.

Top module: `flag_sync_hub`

## Requirements
- R1: While `rst_n` is low at a clock edge, all flags, both enable masks and both interrupt outputs become 0.
- R2: An engine request with `eng_req_valid[e]=1` writes the flag numbered `eng_req_idx` (3 bits, field e at bits 3e+2:3e). A value of 1 in `eng_req_op[e]` sets the flag and 0 clears it. The new value appears on `flags_out` one cycle later.
- R3: When several engines address the same flag in one cycle and at least one of them sets it, the flag ends up 1.
- R4: Engine requests take precedence over host writes to the same flag. An engine clear beats a host set, and an engine set beats a host clear.
- R5: When `host_set_wr` is high, each 1 bit in `host_set_data` sets that flag. When `host_clr_wr` is high, each 1 bit in `host_clr_data` clears that flag. Zero bits have no effect. If the host sets and clears the same flag in one cycle, the set wins.
- R6: A flag that no engine and no host write touches keeps its value.
- R7: `wait_met[e]` is 1 exactly when flag `wait_idx` (field e at bits 3e+2:3e) of the registered flags equals `wait_level[e]`. A flag written in cycle N changes the answer in cycle N+1.
- R8: Each interrupt output `irq_out[l]` is the registered OR of flags 0 to 3 ANDed with enable mask l. It lags the flags by one cycle, and flags 4 to 7 never affect it.
- R9: A pulse on `irq_en_wr[l]` loads `irq_en_data` field l (bits 4l+3:4l) into mask l. The other mask is left alone, and the new mask affects the interrupt one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eng_req_valid | input | 4 | Per-engine request strobe |
| eng_req_op | input | 4 | Per-engine operation, 1 = set, 0 = clear |
| eng_req_idx | input | 12 | Per-engine flag index, 3 bits each |
| wait_idx | input | 12 | Per-engine queried flag index, 3 bits each |
| wait_level | input | 4 | Per-engine level being waited for |
| wait_met | output | 4 | Per-engine wait condition satisfied |
| host_set_wr | input | 1 | Host set-mask write strobe |
| host_set_data | input | 8 | Host write-one-to-set mask |
| host_clr_wr | input | 1 | Host clear-mask write strobe |
| host_clr_data | input | 8 | Host write-one-to-clear mask |
| irq_en_wr | input | 2 | Per-line enable mask write strobe |
| irq_en_data | input | 8 | Enable masks, 4 bits per line |
| flags_out | output | 8 | Registered flag bank |
| irq_out | output | 2 | Registered interrupt lines |

## Verification
The assertions assume that reset is held low from time zero until the first checked edge, and that every index field carries a defined 3-bit value on each cycle, whether or not its strobe is high. The assertion that checks when host clears take effect applies only in cycles with no engine request and no host set. It therefore relies on the stimulus including such quiet host-only cycles. The bench makes sure of this with a directed sequence, and its random phase drives every index with a full-range defined value on every cycle.

// File: rtl/flag_sync_pkg.sv
// Shared sizes and the request encoding for the flag hub.
// Assumes: flag count is a power of two so indices use every code.
package flag_sync_pkg;
    localparam int FLAG_COUNT   = 8;
    localparam int ENGINE_COUNT = 4;
    localparam int IRQ_SOURCES  = 4;
    localparam int IRQ_LINES    = 2;

    typedef enum logic {
        OP_CLEAR = 1'b0,
        OP_SET   = 1'b1
    } flag_op_e;
endpackage

// File: rtl/flag_req_decode.sv
// Turns per-engine indexed requests into one set mask and one clear mask.
// Assumes: an invalid request contributes nothing regardless of its fields.
module flag_req_decode
    import flag_sync_pkg::*;
#(
    parameter int NUM_ENG   = ENGINE_COUNT,
    parameter int NUM_FLAGS = FLAG_COUNT,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic [NUM_ENG-1:0]       req_valid,
    input  logic [NUM_ENG-1:0]       req_op,
    input  logic [NUM_ENG*IDX_W-1:0] req_idx,
    output logic [NUM_FLAGS-1:0]     set_mask,
    output logic [NUM_FLAGS-1:0]     clr_mask
);
    logic [NUM_FLAGS-1:0] eng_set [NUM_ENG];
    logic [NUM_FLAGS-1:0] eng_clr [NUM_ENG];

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        logic [IDX_W-1:0] idx;
        assign idx = req_idx[e*IDX_W +: IDX_W];
        // Purpose: one-hot decode of this engine's target flag by operation.
        always_comb begin
            eng_set[e] = '0;
            eng_clr[e] = '0;
            if (req_valid[e]) begin
                if (flag_op_e'(req_op[e]) == OP_SET) eng_set[e][idx] = 1'b1;
                else                                 eng_clr[e][idx] = 1'b1;
            end
        end
    end

    // Purpose: merge all engines into combined masks.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        for (int e = 0; e < NUM_ENG; e++) begin
            set_mask = set_mask | eng_set[e];
            clr_mask = clr_mask | eng_clr[e];
        end
    end
endmodule

// File: rtl/flag_state_reg.sv
// Holds the flag bank and resolves colliding writes per bit.
// Priority per flag: engine set, engine clear, host set, host clear, hold.
// Assumes: host masks are already gated by their write strobes.
module flag_state_reg
    import flag_sync_pkg::*;
#(
    parameter int NUM_FLAGS = FLAG_COUNT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] eng_set,
    input  logic [NUM_FLAGS-1:0] eng_clr,
    input  logic [NUM_FLAGS-1:0] host_set,
    input  logic [NUM_FLAGS-1:0] host_clr,
    output logic [NUM_FLAGS-1:0] flags_q
);
    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        logic nxt;
        // Purpose: pick this flag's next value by fixed priority.
        always_comb begin
            if (eng_set[f])       nxt = 1'b1;
            else if (eng_clr[f])  nxt = 1'b0;
            else if (host_set[f]) nxt = 1'b1;
            else if (host_clr[f]) nxt = 1'b0;
            else                  nxt = flags_q[f];
        end
        // Purpose: store the flag, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) flags_q[f] <= 1'b0;
            else        flags_q[f] <= nxt;
        end
    end
endmodule

// File: rtl/flag_wait_eval.sv
// Answers each engine's wait query from the registered flag bank.
// Assumes: the flag input is a register output, so answers lag writes by one cycle.
module flag_wait_eval
    import flag_sync_pkg::*;
#(
    parameter int NUM_ENG   = ENGINE_COUNT,
    parameter int NUM_FLAGS = FLAG_COUNT,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic [NUM_FLAGS-1:0]     flags,
    input  logic [NUM_ENG*IDX_W-1:0] wait_idx,
    input  logic [NUM_ENG-1:0]       wait_level,
    output logic [NUM_ENG-1:0]       wait_met
);
    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        // Purpose: compare the selected flag against the awaited level.
        always_comb begin
            wait_met[e] = (flags[wait_idx[e*IDX_W +: IDX_W]] == wait_level[e]);
        end
    end
endmodule

// File: rtl/irq_line_gen.sv
// Per interrupt line: an enable mask register and a registered masked OR.
// Assumes: only the low IRQ_SRC flags are offered as interrupt sources.
module irq_line_gen
    import flag_sync_pkg::*;
#(
    parameter int IRQ_SRC = IRQ_SOURCES,
    parameter int LINES   = IRQ_LINES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IRQ_SRC-1:0]       src,
    input  logic [LINES-1:0]         en_wr,
    input  logic [LINES*IRQ_SRC-1:0] en_data,
    output logic [LINES-1:0]         irq
);
    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [IRQ_SRC-1:0] en_q;
        // Purpose: load this line's enable mask on its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)       en_q <= '0;
            else if (en_wr[l]) en_q <= en_data[l*IRQ_SRC +: IRQ_SRC];
        end
        // Purpose: register the masked OR of the interrupt sources.
        always_ff @(posedge clk) begin
            if (!rst_n) irq[l] <= 1'b0;
            else        irq[l] <= |(src & en_q);
        end
    end
endmodule

// File: rtl/flag_sync_hub.sv
// Top: shared flag bank written by engines and host, with wait queries
// and masked interrupt lines driven from the low flags.
// Assumes: all inputs are synchronous to clk.
module flag_sync_hub
    import flag_sync_pkg::*;
#(
    parameter int NUM_ENG   = ENGINE_COUNT,
    parameter int NUM_FLAGS = FLAG_COUNT,
    parameter int IRQ_SRC   = IRQ_SOURCES,
    parameter int LINES     = IRQ_LINES,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_ENG-1:0]       eng_req_valid,
    input  logic [NUM_ENG-1:0]       eng_req_op,
    input  logic [NUM_ENG*IDX_W-1:0] eng_req_idx,
    input  logic [NUM_ENG*IDX_W-1:0] wait_idx,
    input  logic [NUM_ENG-1:0]       wait_level,
    output logic [NUM_ENG-1:0]       wait_met,
    input  logic                     host_set_wr,
    input  logic [NUM_FLAGS-1:0]     host_set_data,
    input  logic                     host_clr_wr,
    input  logic [NUM_FLAGS-1:0]     host_clr_data,
    input  logic [LINES-1:0]         irq_en_wr,
    input  logic [LINES*IRQ_SRC-1:0] irq_en_data,
    output logic [NUM_FLAGS-1:0]     flags_out,
    output logic [LINES-1:0]         irq_out
);
    logic [NUM_FLAGS-1:0] eng_set, eng_clr, host_set, host_clr, flags_q;

    // Purpose: gate host masks with their strobes.
    always_comb begin
        host_set = host_set_wr ? host_set_data : '0;
        host_clr = host_clr_wr ? host_clr_data : '0;
    end

    flag_req_decode #(.NUM_ENG(NUM_ENG), .NUM_FLAGS(NUM_FLAGS)) u_decode (
        .req_valid (eng_req_valid),
        .req_op    (eng_req_op),
        .req_idx   (eng_req_idx),
        .set_mask  (eng_set),
        .clr_mask  (eng_clr)
    );

    flag_state_reg #(.NUM_FLAGS(NUM_FLAGS)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .eng_set  (eng_set),
        .eng_clr  (eng_clr),
        .host_set (host_set),
        .host_clr (host_clr),
        .flags_q  (flags_q)
    );

    flag_wait_eval #(.NUM_ENG(NUM_ENG), .NUM_FLAGS(NUM_FLAGS)) u_wait (
        .flags      (flags_q),
        .wait_idx   (wait_idx),
        .wait_level (wait_level),
        .wait_met   (wait_met)
    );

    irq_line_gen #(.IRQ_SRC(IRQ_SRC), .LINES(LINES)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (flags_q[IRQ_SRC-1:0]),
        .en_wr   (irq_en_wr),
        .en_data (irq_en_data),
        .irq     (irq_out)
    );

    assign flags_out = flags_q;
endmodule

// File: rtl/flag_sync_hub_checker.sv
// Temporal checks on the flag hub's ports, bound into every instance.
// Assumes: reset is low at the first clock edge.
module flag_sync_hub_checker
    import flag_sync_pkg::*;
#(
    parameter int NUM_ENG   = ENGINE_COUNT,
    parameter int NUM_FLAGS = FLAG_COUNT,
    parameter int IRQ_SRC   = IRQ_SOURCES,
    parameter int LINES     = IRQ_LINES,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_ENG-1:0]       eng_req_valid,
    input logic [NUM_ENG-1:0]       eng_req_op,
    input logic [NUM_ENG*IDX_W-1:0] eng_req_idx,
    input logic [NUM_ENG*IDX_W-1:0] wait_idx,
    input logic [NUM_ENG-1:0]       wait_level,
    input logic [NUM_ENG-1:0]       wait_met,
    input logic                     host_set_wr,
    input logic [NUM_FLAGS-1:0]     host_set_data,
    input logic                     host_clr_wr,
    input logic [NUM_FLAGS-1:0]     host_clr_data,
    input logic [LINES-1:0]         irq_en_wr,
    input logic [LINES*IRQ_SRC-1:0] irq_en_data,
    input logic [NUM_FLAGS-1:0]     flags_out,
    input logic [LINES-1:0]         irq_out
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (flags_out == '0 && irq_out == '0));

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        assert_engine_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (eng_req_valid[e] && eng_req_op[e])
            |=> flags_out[$past(eng_req_idx[e*IDX_W +: IDX_W])]);

        assert_wait_answer_R7: assert property (@(posedge clk) disable iff (!rst_n)
            wait_met[e] == (flags_out[wait_idx[e*IDX_W +: IDX_W]] == wait_level[e]));
    end

    assert_host_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req_valid == '0 && !host_set_wr && host_clr_wr)
        |=> ((flags_out & $past(host_clr_data)) == '0));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req_valid == '0 && !host_set_wr && !host_clr_wr) |=> $stable(flags_out));

    assert_quiet_sources_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_out[IRQ_SRC-1:0] == '0) |=> (irq_out == '0));
endmodule

bind flag_sync_hub flag_sync_hub_checker #(
    .NUM_ENG(NUM_ENG), .NUM_FLAGS(NUM_FLAGS), .IRQ_SRC(IRQ_SRC), .LINES(LINES)
) u_checker (.*);

// File: tb/test_flag_sync_hub.sv
module test_flag_sync_hub;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;
    localparam int NF = 8;
    localparam int IW = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NE-1:0]   eng_req_valid, eng_req_op, wait_level, wait_met;
    logic [NE*IW-1:0] eng_req_idx, wait_idx;
    logic            host_set_wr, host_clr_wr;
    logic [NF-1:0]   host_set_data, host_clr_data, flags_out;
    logic [1:0]      irq_en_wr, irq_out;
    logic [7:0]      irq_en_data;

    int checks = 0;
    int fails  = 0;

    logic [NF-1:0] m_flags;
    logic [3:0]    m_en [2];
    logic [1:0]    m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_sync_hub i_flag_sync_hub (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected next flag bank from the priority rules of R2..R6.
    function automatic logic [NF-1:0] next_flags(input logic [NF-1:0] cur);
        logic [NF-1:0] es = '0, ec = '0, n;
        for (int e = 0; e < NE; e++)
            if (eng_req_valid[e]) begin
                if (eng_req_op[e]) es[eng_req_idx[e*IW +: IW]] = 1'b1;
                else               ec[eng_req_idx[e*IW +: IW]] = 1'b1;
            end
        n = cur;
        n = host_clr_wr ? (n & ~host_clr_data) : n;
        n = host_set_wr ? (n | host_set_data) : n;
        n = (n & ~ec) | es;
        return n;
    endfunction

    function automatic logic [NE-1:0] exp_wait(input logic [NF-1:0] f);
        logic [NE-1:0] w;
        for (int e = 0; e < NE; e++)
            w[e] = (f[wait_idx[e*IW +: IW]] == wait_level[e]);
        return w;
    endfunction

    task automatic idle_inputs();
        eng_req_valid = '0; eng_req_op = '0; eng_req_idx = '0;
        host_set_wr = 0; host_set_data = '0; host_clr_wr = 0; host_clr_data = '0;
        irq_en_wr = '0; irq_en_data = '0;
    endtask

    task automatic eng(input int e, input logic op, input logic [2:0] idx);
        eng_req_valid[e] = 1'b1;
        eng_req_op[e] = op;
        eng_req_idx[e*IW +: IW] = idx;
    endtask

    // Advance one cycle, update the model, then check at the falling edge.
    task automatic step(input string tag);
        logic [NF-1:0] nf;
        nf = next_flags(m_flags);
        @(posedge clk);
        for (int l = 0; l < 2; l++) m_irq[l] = |(m_flags[3:0] & m_en[l]);
        for (int l = 0; l < 2; l++) if (irq_en_wr[l]) m_en[l] = irq_en_data[l*4 +: 4];
        m_flags = nf;
        @(negedge clk);
        idle_inputs();
        #1;
        check({tag, " flags"}, 32'(flags_out), 32'(m_flags));
        check("R8 R9 irq", 32'(irq_out), 32'(m_irq));
        check("R7 wait", 32'(wait_met), 32'(exp_wait(m_flags)));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0;
        idle_inputs();
        wait_idx = '0; wait_level = '0;
        m_flags = '0; m_en[0] = '0; m_en[1] = '0; m_irq = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        check("R1 flags reset", 32'(flags_out), 32'h0);
        check("R1 irq reset", 32'(irq_out), 32'h0);

        // R2: engine 1 sets flag 6, engine 3 sets flag 0.
        @(negedge clk); eng(1, 1, 3'd6); eng(3, 1, 3'd0); step("R2");
        // R3: set and clear collide on flag 5.
        eng(0, 1, 3'd5); eng(2, 0, 3'd5); step("R3");
        // R4: engine clear beats host set on flag 2; engine set beats host clear on 7.
        host_set_wr = 1; host_set_data = 8'h04; eng(1, 0, 3'd2);
        host_clr_wr = 1; host_clr_data = 8'h80; eng(3, 1, 3'd7); step("R4");
        // R5: host clear with zero mask changes nothing.
        host_clr_wr = 1; host_clr_data = 8'h00; step("R5 zero");
        // R5: host clears flags 0 and 5 alone.
        host_clr_wr = 1; host_clr_data = 8'h21; step("R5 clear");
        // R5: host set and clear collide on flag 3 -> set.
        host_set_wr = 1; host_set_data = 8'h08; host_clr_wr = 1; host_clr_data = 8'h08; step("R5 both");
        // R6: idle hold.
        step("R6");
        // R9: enable line 1 for flag 3 only, leave line 0 off.
        irq_en_wr = 2'b10; irq_en_data = 8'h80; step("R9");
        step("R9 irq");
        // R8: fully enable line 0, clear low flags, keep upper ones.
        irq_en_wr = 2'b01; irq_en_data = 8'h0F; host_clr_wr = 1; host_clr_data = 8'h0F; step("R8");
        step("R8 upper");
        // R7: engine 2 waits for flag 1 high; set it, answer flips next cycle.
        wait_idx[2*IW +: IW] = 3'd1; wait_level[2] = 1'b1;
        #1; check("R7 before", 32'(wait_met[2]), 32'h0);
        eng(0, 1, 3'd1); step("R7");
        check("R7 released", 32'(wait_met[2]), 32'h1);

        // Random phase.
        for (int i = 0; i < 400; i++) begin
            eng_req_valid = 4'($urandom() & $urandom());
            eng_req_op    = 4'($urandom());
            eng_req_idx   = 12'($urandom());
            wait_idx      = 12'($urandom());
            wait_level    = 4'($urandom());
            host_set_wr   = ($urandom() % 4) == 0;
            host_set_data = 8'($urandom());
            host_clr_wr   = ($urandom() % 3) == 0;
            host_clr_data = 8'($urandom());
            irq_en_wr     = 2'($urandom() % 8 == 0 ? $urandom() : 0);
            irq_en_data   = 8'($urandom());
            step("R2 R6 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule